// File: doc/BRIEF.md
# ADC Offset and Gain Correction Path

This block is the digital trim stage that follows the decimation filter of a 24-bit sigma-delta converter. Each raw conversion word has a signed offset term taken off first. The difference is then multiplied by an unsigned fixed-point gain coefficient, rounded, clamped to the 24-bit output range and written out with a saturation flag. The offset coefficient is centred on mid-code. The gain coefficient carries 22 fractional bits. Its reset value is about 4/3, which undoes the 3/4 front-end attenuation, so one offset LSB weighs about 1.33 output LSBs.

Software loads the two coefficients through write strobes at any time. A mode input selects unipolar coding or bipolar coding. Unipolar coding is straight binary and uses an extra doubling. Bipolar coding is offset binary centred at 0x800000. Both the coefficient pair and the mode are bound to a sample at the cycle it enters, so every result is computed with one consistent set of settings.

Top module: `adc_trim_path`

## Requirements
- R1: The value subtracted from the raw word is (offset coefficient − 0x800000), and it is subtracted before the gain is applied. An offset coefficient of 0x800000 leaves the raw word uncorrected, and a coefficient of 0x7FFFF0 adds 16 raw counts.
- R2: The gain factor equals the gain coefficient / 2^22 (unsigned). The scaled result is rounded half-up on the discarded bits, and a coefficient of 0 gives a result of zero.
- R3: With bipolar_mode = 0 (unipolar), out_data = round(diff × gain / 2^21), in straight binary. For example, raw 0x300000 at gain 0x555555 gives 0x800000, and raw 0x600000 gives 0xFFFFFF.
- R4: With bipolar_mode = 1, the raw word is read as offset binary. out_data = 0x800000 + round((diff − 0x800000) × gain / 2^22), and the result is not doubled.
- R5: A result below 0 is clamped to 0x000000, and a result above 0xFFFFFF is clamped to 0xFFFFFF. out_sat is 1 for exactly those samples and 0 for every sample in range.
- R6: out_valid is high in the cycle two clock edges after the edge that samples in_valid high. It is low one edge after that sample, and each input sample produces exactly one output cycle.
- R7: A coefficient write in the same cycle as an input sample does not affect that sample, only later ones. The mode is captured together with its sample.
- R8: After reset, out_valid, out_data and out_sat are 0. The coefficients reset to offset 0x800000 and gain 0x555555.
- R9: While no sample completes, out_data and out_sat hold their last values.
- R10: A coefficient register keeps its value while its write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample strobe |
| in_raw | input | 24 | Raw conversion word |
| bipolar_mode | input | 1 | 1 selects bipolar coding, 0 selects unipolar coding |
| off_wr | input | 1 | Offset coefficient write strobe |
| off_wdata | input | 24 | Offset coefficient write value |
| gain_wr | input | 1 | Gain coefficient write strobe |
| gain_wdata | input | 24 | Gain coefficient write value |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 24 | Corrected, coded output word |
| out_sat | output | 1 | Clamping occurred for this sample |

## Verification
The bench builds the block with its default parameters: a 24-bit data width, a 24-bit gain coefficient with 22 fractional bits, and a reset gain of 0x555555. At these values the real codes of the converter are reachable. These include the nominal 4/3 gain, which turns raw 0x300000 into exact midscale and raw 0x600000 into exact full scale, and the 1.33-to-1 weighting of offset LSBs. The same values also reach the exact half-LSB rounding ties on both polarities, and a bipolar tie that rounds up and overflows by one code. The bench also reaches both clamp rails, a write in the same cycle as a sample, and back-to-back samples in different modes.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;
  typedef enum logic {
    CODE_UNIPOLAR = 1'b0,
    CODE_BIPOLAR  = 1'b1
  } code_mode_e;
endpackage

// File: rtl/adc_trim_coef.sv
module adc_trim_coef #(
  parameter int          DATA_W   = 24,
  parameter int          GAIN_W   = 24,
  parameter logic [23:0] GAIN_RST = 24'h555555
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              off_wr,
  input  logic [DATA_W-1:0] off_wdata,
  input  logic              gain_wr,
  input  logic [GAIN_W-1:0] gain_wdata,
  output logic [DATA_W-1:0] off_q,
  output logic [GAIN_W-1:0] gain_q
);
  localparam logic [DATA_W-1:0] OFF_ZERO = DATA_W'(1) << (DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= OFF_ZERO;
      gain_q <= GAIN_W'(GAIN_RST);
    end else begin
      if (off_wr)  off_q  <= off_wdata;
      if (gain_wr) gain_q <= gain_wdata;
    end
  end

  // R10: coefficients hold without a write strobe
  p_off_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !off_wr |=> $stable(off_q));
  p_gain_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !gain_wr |=> $stable(gain_q));
  // R8: reset values of the coefficient pair
  p_reset_coef_r8: assert property (@(posedge clk)
    rst |=> (off_q == OFF_ZERO && gain_q == GAIN_W'(GAIN_RST)));
endmodule

// File: rtl/adc_trim_offset.sv
module adc_trim_offset
  import adc_trim_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 24,
  localparam int DIFF_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_raw,
  input  code_mode_e               in_mode,
  input  logic [DATA_W-1:0]        off_q,
  input  logic [GAIN_W-1:0]        gain_q,
  output logic                     s1_valid,
  output logic signed [DIFF_W-1:0] s1_diff,
  output logic [GAIN_W-1:0]        s1_gain,
  output code_mode_e               s1_mode
);
  localparam logic signed [DIFF_W-1:0] MID = DIFF_W'(1) <<< (DATA_W - 1);

  logic signed [DIFF_W-1:0] raw_ext, off_term, centre, diff_c;

  always_comb begin
    raw_ext  = $signed({2'b00, in_raw});
    off_term = $signed({2'b00, off_q}) - MID;
    centre   = (in_mode == CODE_BIPOLAR) ? MID : '0;
    diff_c   = raw_ext - off_term - centre;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_diff  <= '0;
      s1_gain  <= '0;
      s1_mode  <= CODE_UNIPOLAR;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_diff <= diff_c;
        s1_gain <= gain_q;
        s1_mode <= in_mode;
      end
    end
  end

  // R6: first pipeline step tracks the input strobe
  p_stage1_valid_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  p_stage1_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_valid);
  // R7: captured gain is the one in force when the sample arrived
  p_gain_capture_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_gain == $past(gain_q));
endmodule

// File: rtl/adc_trim_scale.sv
module adc_trim_scale
  import adc_trim_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 24,
  parameter int FRAC_W = 22,
  localparam int DIFF_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  logic signed [DIFF_W-1:0] s1_diff,
  input  logic [GAIN_W-1:0]        s1_gain,
  input  code_mode_e               s1_mode,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_sat
);
  localparam int PROD_W = DIFF_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HALF_U  = PROD_W'(longint'(1) << (FRAC_W - 2));
  localparam logic signed [PROD_W-1:0] HALF_B  = PROD_W'(longint'(1) << (FRAC_W - 1));
  localparam logic signed [PROD_W-1:0] MID_EXT = PROD_W'(longint'(1) << (DATA_W - 1));
  localparam logic signed [PROD_W-1:0] MAX_EXT = PROD_W'((longint'(1) << DATA_W) - 1);
  localparam logic [DATA_W-1:0]        MAX_CODE = '1;

  logic signed [PROD_W-1:0] prod, scaled_u, scaled_b, res;
  logic [DATA_W-1:0] clamped;
  logic              clipped;

  always_comb begin
    prod     = PROD_W'(s1_diff) * $signed({1'b0, s1_gain});
    scaled_u = (prod + HALF_U) >>> (FRAC_W - 1);
    scaled_b = (prod + HALF_B) >>> FRAC_W;
    res      = (s1_mode == CODE_BIPOLAR) ? scaled_b + MID_EXT : scaled_u;
    if (res[PROD_W-1]) begin
      clamped = '0;
      clipped = 1'b1;
    end else if (res > MAX_EXT) begin
      clamped = MAX_CODE;
      clipped = 1'b1;
    end else begin
      clamped = res[DATA_W-1:0];
      clipped = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data <= clamped;
        out_sat  <= clipped;
      end
    end
  end

  // R6: second pipeline step tracks the first
  p_out_valid_r6: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  p_out_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);
  // R5: a flagged sample sits on a rail
  p_sat_rail_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sat) |-> (out_data == '0 || out_data == MAX_CODE));
  // R9: outputs hold between samples
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> ($stable(out_data) && $stable(out_sat)));
  // R2: zero gain can never clip in unipolar mode
  p_zero_gain_r2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_gain == '0 && s1_mode == CODE_UNIPOLAR) |=> (out_data == '0 && !out_sat));
endmodule

// File: rtl/adc_trim_path.sv
module adc_trim_path
  import adc_trim_pkg::*;
#(
  parameter int          DATA_W   = 24,
  parameter int          GAIN_W   = 24,
  parameter int          FRAC_W   = 22,
  parameter logic [23:0] GAIN_RST = 24'h555555
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_raw,
  input  logic              bipolar_mode,
  input  logic              off_wr,
  input  logic [DATA_W-1:0] off_wdata,
  input  logic              gain_wr,
  input  logic [GAIN_W-1:0] gain_wdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sat
);
  localparam int DIFF_W = DATA_W + 2;

  logic [DATA_W-1:0]        off_q;
  logic [GAIN_W-1:0]        gain_q;
  logic                     s1_valid;
  logic signed [DIFF_W-1:0] s1_diff;
  logic [GAIN_W-1:0]        s1_gain;
  code_mode_e               s1_mode;
  code_mode_e               in_mode;

  assign in_mode = bipolar_mode ? CODE_BIPOLAR : CODE_UNIPOLAR;

  adc_trim_coef #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_RST(GAIN_RST)) u_coef (
    .clk(clk), .rst(rst),
    .off_wr(off_wr), .off_wdata(off_wdata),
    .gain_wr(gain_wr), .gain_wdata(gain_wdata),
    .off_q(off_q), .gain_q(gain_q)
  );

  adc_trim_offset #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_offset (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_raw(in_raw), .in_mode(in_mode),
    .off_q(off_q), .gain_q(gain_q),
    .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_gain(s1_gain), .s1_mode(s1_mode)
  );

  adc_trim_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_scale (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_gain(s1_gain), .s1_mode(s1_mode),
    .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat)
  );

  // R8: reset clears the output port
  p_reset_out_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_sat));
endmodule

// File: tb/adc_trim_path_bench.sv
module adc_trim_path_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic        bi;
    logic [23:0] raw;
    logic [23:0] off;
    logic [23:0] gain;
    logic [23:0] exp;
    logic        sat;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 24'h000000, 24'h800000, 24'h400000, 24'h000000, 1'b0},
    '{1'b0, 24'h100000, 24'h800000, 24'h400000, 24'h200000, 1'b0},
    '{1'b0, 24'h600000, 24'h800000, 24'h555555, 24'hFFFFFF, 1'b0},
    '{1'b0, 24'h300000, 24'h800000, 24'h555555, 24'h800000, 1'b0},
    '{1'b0, 24'h900000, 24'h800000, 24'h400000, 24'hFFFFFF, 1'b1},
    '{1'b0, 24'h100000, 24'h800010, 24'h400000, 24'h1FFFE0, 1'b0},
    '{1'b0, 24'h000005, 24'h800010, 24'h400000, 24'h000000, 1'b1},
    '{1'b1, 24'h800000, 24'h800000, 24'h555555, 24'h800000, 1'b0},
    '{1'b1, 24'hA00000, 24'h800000, 24'h400000, 24'hA00000, 1'b0},
    '{1'b1, 24'h200000, 24'h800000, 24'h555555, 24'h000001, 1'b0},
    '{1'b1, 24'hE00000, 24'h800000, 24'h555555, 24'hFFFFFF, 1'b1},
    '{1'b1, 24'h900000, 24'h800000, 24'h466666, 24'h91999A, 1'b0},
    '{1'b1, 24'h800000, 24'h7FFFF0, 24'h555555, 24'h800015, 1'b0},
    '{1'b1, 24'h000000, 24'h800000, 24'h555555, 24'h000000, 1'b1},
    '{1'b0, 24'h123456, 24'h800000, 24'h000000, 24'h000000, 1'b0}
  };
  localparam string TAGS [NV] = '{
    "R3", "R3", "R3", "R2", "R5", "R1", "R5",
    "R4", "R4", "R2", "R5", "R2", "R1", "R5", "R2"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_raw = '0;
  logic        bipolar_mode = 1'b0;
  logic        off_wr = 1'b0;
  logic [23:0] off_wdata = '0;
  logic        gain_wr = 1'b0;
  logic [23:0] gain_wdata = '0;
  logic        out_valid;
  logic [23:0] out_data;
  logic        out_sat;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_trim_path u_adc_trim_path (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_raw(in_raw), .bipolar_mode(bipolar_mode),
    .off_wr(off_wr), .off_wdata(off_wdata),
    .gain_wr(gain_wr), .gain_wdata(gain_wdata),
    .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_coef(input logic [23:0] off, input logic [23:0] gain);
    @(negedge clk);
    off_wr = 1'b1; off_wdata = off;
    gain_wr = 1'b1; gain_wdata = gain;
    @(negedge clk);
    off_wr = 1'b0; gain_wr = 1'b0;
  endtask

  task automatic run_sample(input string tag, input logic bi, input logic [23:0] raw,
                            input logic [23:0] exp, input logic sat);
    @(negedge clk);
    in_valid = 1'b1; in_raw = raw; bipolar_mode = bi;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 valid low after one edge", {23'd0, out_valid}, 24'd0);
    @(negedge clk);
    chk("R6 valid after two edges", {23'd0, out_valid}, 24'd1);
    chk(tag, out_data, exp);
    chk({tag, " sat"}, {23'd0, out_sat}, {23'd0, sat});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: outputs during and after reset
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", {23'd0, out_valid}, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 data after reset", out_data, 24'd0);
    chk("R8 sat after reset", {23'd0, out_sat}, 24'd0);
    // R8: reset coefficients give nominal gain, no offset
    run_sample("R8 reset coefficients", 1'b0, 24'h300000, 24'h800000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      set_coef(VECS[i].off, VECS[i].gain);
      run_sample(TAGS[i], VECS[i].bi, VECS[i].raw, VECS[i].exp, VECS[i].sat);
    end

    // R9: outputs hold during idle cycles
    repeat (3) @(negedge clk);
    chk("R9 data holds", out_data, 24'h000000);
    chk("R9 sat holds", {23'd0, out_sat}, 24'd0);
    chk("R6 no extra valid", {23'd0, out_valid}, 24'd0);

    // R7: write in the same cycle as a sample
    set_coef(24'h800000, 24'h400000);
    @(negedge clk);
    in_valid = 1'b1; in_raw = 24'h100000; bipolar_mode = 1'b0;
    gain_wr = 1'b1; gain_wdata = 24'h200000;
    @(negedge clk);
    in_valid = 1'b0; gain_wr = 1'b0;
    @(negedge clk);
    chk("R7 same-cycle write uses old gain", out_data, 24'h200000);
    // R7 and R10: the new gain applies to the next sample and persists
    run_sample("R7 new gain applies", 1'b0, 24'h100000, 24'h100000, 1'b0);
    run_sample("R10 gain persists", 1'b0, 24'h080000, 24'h080000, 1'b0);

    // R7: back-to-back samples with different modes
    set_coef(24'h800000, 24'h400000);
    @(negedge clk);
    in_valid = 1'b1; in_raw = 24'h100000; bipolar_mode = 1'b0;
    @(negedge clk);
    in_raw = 24'hA00000; bipolar_mode = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; bipolar_mode = 1'b0;
    chk("R7 first of pair", out_data, 24'h200000);
    chk("R6 first valid", {23'd0, out_valid}, 24'd1);
    @(negedge clk);
    chk("R7 second of pair", out_data, 24'hA00000);
    chk("R6 second valid", {23'd0, out_valid}, 24'd1);
    @(negedge clk);
    chk("R6 valid ends", {23'd0, out_valid}, 24'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule